// File: doc/BRIEF.md
# Framed RGB command parser

This block sits behind a byte receiver (for instance a UART) and turns a stream of received bytes into a colour setting for three 8-bit channels: red, green and blue. It looks for a five-byte frame. The frame opens with a start marker. Three colour bytes follow, and a closing marker ends it. Each byte is taken only in a cycle where its valid strobe is high. Idle cycles between bytes have no effect.

The colour bytes go first into shadow registers. The three output registers change together, and only when the closing marker is correct. On a good frame the block raises a one-cycle update pulse. On a frame with a wrong closing marker it raises a one-cycle error pulse, throws the shadow contents away and leaves the outputs unchanged. In both cases the parser goes back to hunting for a start marker. Inside the three colour positions the marker values are ordinary data.

Top module: `rgbf_cmd_parser`

## Requirements
- R1: While reset is high and in the first cycle after it, every colour output holds 1 and both pulses are low.
- R2: While hunting, a valid byte other than the start marker 0xAA is ignored and the parser keeps hunting. Such a byte cannot start a frame, and no output changes.
- R3: After a valid 0xAA, the next three valid bytes are red, green and blue, in that order. If the fifth valid byte is the closing marker 0x55, all three outputs take the new values together in the cycle after that byte, and the update pulse is high for exactly that one cycle.
- R4: If the fifth valid byte is not 0x55, the outputs keep their earlier values and the error pulse is high for exactly one cycle, in the cycle after that byte.
- R5: After the fifth byte, whether it was good or bad, the parser is hunting again. A following frame body sent without its own 0xAA has no effect.
- R6: A colour byte equal to 0xAA or 0x55 is stored as colour data. It is not taken as a marker.
- R7: A byte whose valid strobe is low is ignored in every state, so any number of idle cycles may fall between the bytes of a frame.
- R8: The update and error pulses are never high together, and neither stays high for two cycles in a row.
- R9: The colour outputs change only in a cycle where the update pulse is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | High for one cycle per received byte |
| red_o | output | 8 | Committed red level |
| grn_o | output | 8 | Committed green level |
| blu_o | output | 8 | Committed blue level |
| upd_o | output | 1 | One-cycle pulse after a committed frame |
| err_o | output | 1 | One-cycle pulse after a frame with a bad closing marker |

## Verification
The assertions check on every cycle the pulse rules, and that each pulse follows a valid closing-position byte of the right kind. They also check that colours never move without an update pulse, that the sequencer stays in the hunting state on a non-start byte, and that it always goes back to hunting after the fifth byte. Only the bench's scenarios can show that the right byte ends up in the right channel, and that a bad frame leaves the earlier colours in place. They also show that markers in the data positions are stored as data, that gaps with junk on the data lines have no effect, and that a frame body sent without its opening marker changes nothing.

// File: rtl/rgbf_pkg.sv
package rgbf_pkg;

    localparam int CH_W = 8;
    localparam int N_CH = 3;

    localparam int CH_RED = 0;
    localparam int CH_GRN = 1;
    localparam int CH_BLU = 2;

    typedef logic [CH_W-1:0]     chan_t;
    typedef chan_t [N_CH-1:0]    chan_vec_t;

    localparam chan_t DEF_START = 8'hAA;
    localparam chan_t DEF_END   = 8'h55;
    localparam chan_t DEF_LEVEL = 8'h01;

    typedef enum logic [2:0] {
        ST_HUNT = 3'd0,
        ST_RED  = 3'd1,
        ST_GRN  = 3'd2,
        ST_BLU  = 3'd3,
        ST_TAIL = 3'd4
    } fr_state_e;

    typedef struct packed {
        logic [N_CH-1:0] cap;
        logic            tail_ok;
        logic            tail_bad;
    } seq_ctl_t;

    function automatic logic [N_CH-1:0] cap_sel(input fr_state_e st);
        logic [N_CH-1:0] v;
        v = '0;
        case (st)
            ST_RED:  v[CH_RED] = 1'b1;
            ST_GRN:  v[CH_GRN] = 1'b1;
            ST_BLU:  v[CH_BLU] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rgbf_seq.sv
module rgbf_seq
    import rgbf_pkg::*;
#(
    parameter chan_t START_MARK = DEF_START,
    parameter chan_t END_MARK   = DEF_END
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     byte_vld,
    input  chan_t    byte_dat,
    output seq_ctl_t ctl_o
);

    fr_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (byte_vld) begin
            case (st_q)
                ST_HUNT: if (byte_dat == START_MARK) st_d = ST_RED;
                ST_RED:  st_d = ST_GRN;
                ST_GRN:  st_d = ST_BLU;
                ST_BLU:  st_d = ST_TAIL;
                ST_TAIL: st_d = ST_HUNT;
                default: st_d = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_HUNT;
        else     st_q <= st_d;
    end

    always_comb begin
        ctl_o          = '0;
        ctl_o.cap      = byte_vld ? cap_sel(st_q) : '0;
        ctl_o.tail_ok  = byte_vld && (st_q == ST_TAIL) && (byte_dat == END_MARK);
        ctl_o.tail_bad = byte_vld && (st_q == ST_TAIL) && (byte_dat != END_MARK);
    end

    assert_hunt_stay_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HUNT && !(byte_vld && byte_dat == START_MARK)) |=> (st_q == ST_HUNT));

    assert_tail_back_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TAIL && byte_vld) |=> (st_q == ST_HUNT));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> $stable(st_q));

endmodule

// File: rtl/rgbf_shadow.sv
module rgbf_shadow
    import rgbf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] cap,
    input  chan_t           byte_dat,
    output chan_vec_t       shadow_o
);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        chan_t sh_q;
        always_ff @(posedge clk) begin
            if (rst)         sh_q <= '0;
            else if (cap[i]) sh_q <= byte_dat;
        end
        assign shadow_o[i] = sh_q;
    end

    assert_cap_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cap));

endmodule

// File: rtl/rgbf_commit.sv
module rgbf_commit
    import rgbf_pkg::*;
#(
    parameter chan_t RESET_LEVEL = DEF_LEVEL
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tail_ok,
    input  logic      tail_bad,
    input  chan_vec_t shadow,
    output chan_vec_t colour_o,
    output logic      upd_o,
    output logic      err_o
);

    chan_vec_t colour_q;
    logic      upd_q, err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CH; i++) colour_q[i] <= RESET_LEVEL;
            upd_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (tail_ok) colour_q <= shadow;
            upd_q <= tail_ok;
            err_q <= tail_bad;
        end
    end

    assign colour_o = colour_q;
    assign upd_o    = upd_q;
    assign err_o    = err_q;

    assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(upd_q && err_q));

    assert_upd_single_R8: assert property (@(posedge clk) disable iff (rst)
        upd_q |=> !upd_q);

    assert_err_single_R8: assert property (@(posedge clk) disable iff (rst)
        err_q |=> !err_q);

endmodule

// File: rtl/rgbf_cmd_parser.sv
module rgbf_cmd_parser
    import rgbf_pkg::*;
#(
    parameter logic [7:0] START_MARK  = 8'hAA,
    parameter logic [7:0] END_MARK    = 8'h55,
    parameter logic [7:0] RESET_LEVEL = 8'h01
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output logic [7:0] red_o,
    output logic [7:0] grn_o,
    output logic [7:0] blu_o,
    output logic       upd_o,
    output logic       err_o
);

    seq_ctl_t  ctl;
    chan_vec_t shadow;
    chan_vec_t colour;

    rgbf_seq #(
        .START_MARK (START_MARK),
        .END_MARK   (END_MARK)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .byte_vld (rx_valid),
        .byte_dat (rx_data),
        .ctl_o    (ctl)
    );

    rgbf_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .cap      (ctl.cap),
        .byte_dat (rx_data),
        .shadow_o (shadow)
    );

    rgbf_commit #(
        .RESET_LEVEL (RESET_LEVEL)
    ) u_commit (
        .clk      (clk),
        .rst      (rst),
        .tail_ok  (ctl.tail_ok),
        .tail_bad (ctl.tail_bad),
        .shadow   (shadow),
        .colour_o (colour),
        .upd_o    (upd_o),
        .err_o    (err_o)
    );

    assign red_o = colour[CH_RED];
    assign grn_o = colour[CH_GRN];
    assign blu_o = colour[CH_BLU];

    assert_reset_val_R1: assert property (@(posedge clk)
        rst |=> (red_o == RESET_LEVEL && grn_o == RESET_LEVEL &&
                 blu_o == RESET_LEVEL && !upd_o && !err_o));

    assert_upd_cause_R3: assert property (@(posedge clk) disable iff (rst)
        upd_o |-> $past(rx_valid && rx_data == END_MARK));

    assert_err_cause_R4: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(rx_valid && rx_data != END_MARK));

    assert_colour_hold_R9: assert property (@(posedge clk) disable iff (rst)
        ({red_o, grn_o, blu_o} != $past({red_o, grn_o, blu_o})) |-> upd_o);

endmodule

// File: tb/sim_rgbf_cmd_parser.sv
`timescale 1ns/1ps
module sim_rgbf_cmd_parser;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_data = 8'h00;
    logic       rx_valid = 1'b0;
    logic [7:0] red_o, grn_o, blu_o;
    logic       upd_o, err_o;

    int checks = 0;
    int fails  = 0;
    int upd_seen = 0;
    int err_seen = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rgbf_cmd_parser u0 (
        .clk      (clk),
        .rst      (rst),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .red_o    (red_o),
        .grn_o    (grn_o),
        .blu_o    (blu_o),
        .upd_o    (upd_o),
        .err_o    (err_o)
    );

    always @(negedge clk) begin
        if (!rst && upd_o) upd_seen++;
        if (!rst && err_o) err_seen++;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic check_rgb(input string tag, input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        check({tag, " red"},   {24'h0, red_o}, {24'h0, r});
        check({tag, " green"}, {24'h0, grn_o}, {24'h0, g});
        check({tag, " blue"},  {24'h0, blu_o}, {24'h0, b});
    endtask

    // one valid byte, then valid drops; returns at the negedge after the capturing edge
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_gap(input logic [7:0] b, input int gap, input logic [7:0] junk);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_data  = junk;
        end
        send(b);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_rgb("R1 during reset", 8'h01, 8'h01, 8'h01);
        check("R1 upd in reset", {31'h0, upd_o}, 32'h0);
        check("R1 err in reset", {31'h0, err_o}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check_rgb("R1 after reset", 8'h01, 8'h01, 8'h01);
        check("R1 pulses after reset", {30'h0, upd_o, err_o}, 32'h0);
    endtask

    task automatic t_good_frame();
        send(8'hAA); send(8'h12); send(8'h34); send(8'h56);
        check_rgb("R3 shadow not visible", 8'h01, 8'h01, 8'h01);
        send(8'h55);
        check_rgb("R3 commit", 8'h12, 8'h34, 8'h56);
        check("R3 upd pulse", {31'h0, upd_o}, 32'h1);
        check("R8 no err with upd", {31'h0, err_o}, 32'h0);
        @(negedge clk);
        check("R8 upd one cycle", {31'h0, upd_o}, 32'h0);
    endtask

    task automatic t_ignore_hunt();
        int u0c;
        u0c = upd_seen;
        send(8'h55); send(8'h00); send(8'hFF); send(8'h12);
        send(8'h9A); send(8'hBC); send(8'hDE); send(8'h55);
        @(negedge clk);
        check("R2 no update from junk", upd_seen - u0c, 0);
        check_rgb("R2 colours kept", 8'h12, 8'h34, 8'h56);
    endtask

    task automatic t_bad_tail();
        int e0c;
        e0c = err_seen;
        send(8'hAA); send(8'h01); send(8'h02); send(8'h03); send(8'h00);
        check("R4 err pulse", {31'h0, err_o}, 32'h1);
        check("R4 no upd", {31'h0, upd_o}, 32'h0);
        check_rgb("R4 outputs kept", 8'h12, 8'h34, 8'h56);
        @(negedge clk);
        check("R4 err one cycle", {31'h0, err_o}, 32'h0);
        check("R4 err count", err_seen - e0c, 1);
        check_rgb("R9 still kept", 8'h12, 8'h34, 8'h56);
    endtask

    task automatic t_back_to_hunt();
        int u0c;
        u0c = upd_seen;
        // body without opener after a bad frame
        send(8'h77); send(8'h88); send(8'h99); send(8'h55);
        @(negedge clk);
        check("R5 body without opener", upd_seen - u0c, 0);
        check_rgb("R5 colours kept", 8'h12, 8'h34, 8'h56);
        // good frame then body without opener
        send(8'hAA); send(8'h21); send(8'h43); send(8'h65); send(8'h55);
        check_rgb("R5 good frame", 8'h21, 8'h43, 8'h65);
        send(8'h11); send(8'h22); send(8'h33); send(8'h55);
        check_rgb("R5 after good frame", 8'h21, 8'h43, 8'h65);
        check("R5 single update", upd_seen - u0c, 1);
    endtask

    task automatic t_marker_data();
        send(8'hAA); send(8'hAA); send(8'h55); send(8'hAA); send(8'h55);
        check("R6 upd", {31'h0, upd_o}, 32'h1);
        check_rgb("R6 markers as data", 8'hAA, 8'h55, 8'hAA);
    endtask

    task automatic t_gaps();
        send_gap(8'hAA, 3, 8'h55);
        send_gap(8'hC1, 5, 8'hAA);
        send_gap(8'hC2, 2, 8'h55);
        send_gap(8'hC3, 7, 8'hAA);
        check_rgb("R7 no early change", 8'hAA, 8'h55, 8'hAA);
        send_gap(8'h55, 4, 8'h00);
        check("R7 upd after gaps", {31'h0, upd_o}, 32'h1);
        check_rgb("R7 gapped frame", 8'hC1, 8'hC2, 8'hC3);
    endtask

    task automatic t_burst();
        logic [7:0] seq [10];
        seq = '{8'hAA, 8'h0F, 8'hF0, 8'h3C, 8'h55, 8'hAA, 8'hE1, 8'hD2, 8'hC3, 8'h55};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i == 5) begin
                check("R3 burst upd 1", {31'h0, upd_o}, 32'h1);
                check_rgb("R3 burst frame 1", 8'h0F, 8'hF0, 8'h3C);
            end
            if (i == 6) check("R8 burst upd drop", {31'h0, upd_o}, 32'h0);
            rx_valid = 1'b1;
            rx_data  = seq[i];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        check("R3 burst upd 2", {31'h0, upd_o}, 32'h1);
        check_rgb("R3 burst frame 2", 8'hE1, 8'hD2, 8'hC3);
    endtask

    initial begin
        t_reset();
        t_good_frame();
        t_ignore_hunt();
        t_bad_tail();
        t_back_to_hunt();
        t_marker_data();
        t_gaps();
        t_burst();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule